// File: doc/BRIEF.md
# Hall-Sensor Brushless Motor Commutation Controller

This block turns the three Hall-switch levels of a three-phase brushless motor into six gate-enable levels for an all-n-channel bridge: one high-side and one low-side enable per phase. Every input is asynchronous to the block clock and passes through a two-flop synchronizer. The Hall levels also pass through a digital glitch filter. The filtered Hall code is decoded for either 60-degree or 120-degree sensor spacing into one of six drive steps. Each step switches on one high side and one low side on two different phases.

The decoded step is modified by the control levels. A direction level exchanges the driven high and low sides. A PWM level chops either the low side alone or both switches, depending on a chop-mode level. A brake level turns on all three low sides. An enable level and an inhibit level from the protection logic both force every gate off. A Hall code that is illegal for the chosen spacing forces the gates off and pulls an active-low fault flag low. Every accepted Hall change produces an active-low tachometer pulse of fixed width, so a full electrical turn yields six pulses.

Top module: `bldc_commutator`

## Requirements
- R1: A clean Hall change reaches the gate outputs exactly 4+FILT_CYC clock edges after it is applied. With the default FILT_CYC=4 this is the 8th rising edge. Nothing changes at the 7th edge.
- R2: A Hall excursion that lasts 2 clock cycles, returning to the previous code, leaves the gates unchanged and produces no tach pulse.
- R3: With 120-degree spacing (sel_60=0), the Hall code is hall[2:0] with bit 0 as phase A. The forward map is 001→high A/low B, 011→high A/low C, 010→high B/low C, 110→high B/low A, 100→high C/low A, 101→high C/low B. Gate bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R4: With 60-degree spacing (sel_60=1), the forward map is 001→high A/low B, 011→high A/low C, 111→high B/low C, 110→high B/low A, 100→high C/low A, 000→high C/low B.
- R5: With dir_fwd=0, the high-side and low-side phases of each step are exchanged.
- R6: Codes 000 and 111 with 120-degree spacing, and codes 010 and 101 with 60-degree spacing, force all six gates off and drive fault_n low. Any legal code drives fault_n high.
- R7: With enable=0, all six gates are off.
- R8: With brake=1, on a legal code and with the block enabled, all three low sides are on and all high sides are off.
- R9: With pwm=0 and chop_both=0, the low side is off and the high side stays on. With pwm=0 and chop_both=1, both are off. With pwm=1, the step drives normally.
- R10: Each accepted Hall change drives tach_n low for exactly TACH_CYC cycles (default 125). The pulse starts on the same edge as the gate update.
- R11: With inhibit=1, all gates are off. On release, the gates follow the Hall code present at that moment.
- R12: A change on a control level (enable, dir_fwd, pwm, chop_both, brake, inhibit, sel_60) reaches the outputs on the 3rd rising edge after it is applied.
- R13: A phase never has its high and low side on together, and at most one high side is on.
- R14: During reset, all gates are off, tach_n is high and fault_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Hall switch levels; bit 0 is phase A, bit 1 is phase B, bit 2 is phase C |
| sel_60 | input | 1 | 1 selects 60-degree spacing, 0 selects 120-degree spacing |
| enable | input | 1 | 1 lets the gates drive |
| dir_fwd | input | 1 | 1 selects forward, 0 selects reverse |
| pwm | input | 1 | Chopping level; 1 means conduct |
| chop_both | input | 1 | 1 chops the high and low side, 0 chops the low side only |
| brake | input | 1 | 1 turns on all low sides |
| inhibit | input | 1 | 1 forces all gates off (from protection logic) |
| gate_top | output | 3 | High-side enables, one bit per phase |
| gate_bot | output | 3 | Low-side enables, one bit per phase |
| tach_n | output | 1 | Active-low pulse on each accepted Hall change |
| fault_n | output | 1 | Low while the Hall code is illegal |

## Verification
Control levels take two synchronizer edges plus the output register, so their results are due on the third rising edge. Hall changes add one edge for the stability compare and FILT_CYC edges of filtering, so they land on the eighth edge with defaults. The tach pulse starts on that same edge. The bench applies every stimulus at a falling edge and counts rising edges from there. The latency checks sample just before and just after the due edge, so that an early or late result is caught. The randomized checks wait well beyond both latencies before comparing against the bench's own model.

// File: rtl/bldc_pkg.sv
// Package: shared types and constants for the commutation controller.
// Assumes phase order A=bit0, B=bit1, C=bit2 in every 3-bit vector.
package bldc_pkg;
    typedef logic [2:0] phase_vec_t;
    typedef logic [2:0] step_t;
    localparam step_t STEP_NONE = 3'd7;
    localparam phase_vec_t PH_A = 3'b001;
    localparam phase_vec_t PH_B = 3'b010;
    localparam phase_vec_t PH_C = 3'b100;
endpackage

// File: rtl/bldc_sync.sv
// Module: multi-bit two-flop synchronizer.
// Assumes each bit is an independent level; no cross-bit coherence is needed.
module bldc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta;

    // Two-stage capture of asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/bldc_hall_filter.sv
// Module: glitch filter for the synchronized Hall code.
// A new code is accepted once it has been stable for FILT_CYC further cycles.
// hall_ok rises at the first acceptance after reset. hall_evt pulses for one
// cycle on each later accepted change.
// Assumes hall_s is already synchronous to clk.
module bldc_hall_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_s,
    output logic [2:0] hall_q,
    output logic       hall_ok,
    output logic       hall_evt
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

    logic [2:0]    prev;
    logic [CW-1:0] cnt;

    // Stability counter and acceptance of the filtered code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= '0;
            cnt      <= '0;
            hall_q   <= '0;
            hall_ok  <= 1'b0;
            hall_evt <= 1'b0;
        end else begin
            prev     <= hall_s;
            hall_evt <= 1'b0;
            if (hall_s != prev || (hall_ok && hall_s == hall_q)) begin
                cnt <= '0;
            end else if (cnt == LIMIT) begin
                hall_q   <= hall_s;
                hall_ok  <= 1'b1;
                hall_evt <= hall_ok;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10
    evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hall_evt |-> (hall_q != $past(hall_q)));

    // R2
    stable_before_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_q != $past(hall_q)) |-> ($past(hall_s) == $past(prev)));
endmodule

// File: rtl/bldc_decode.sv
// Module: combinational Hall-code to drive-step decoder.
// Yields the forward high-side and low-side phase (one-hot) and a legality flag
// for the selected spacing. Assumes code bit 0 belongs to phase A.
module bldc_decode
    import bldc_pkg::*;
(
    input  logic [2:0] code,
    input  logic       sel_60,
    output logic       legal,
    output phase_vec_t hi_fwd,
    output phase_vec_t lo_fwd
);
    step_t step;

    // Map the code to a step index for the selected spacing.
    always_comb begin
        step = STEP_NONE;
        if (sel_60) begin
            case (code)
                3'b001: step = 3'd0;
                3'b011: step = 3'd1;
                3'b111: step = 3'd2;
                3'b110: step = 3'd3;
                3'b100: step = 3'd4;
                3'b000: step = 3'd5;
                default: step = STEP_NONE;
            endcase
        end else begin
            case (code)
                3'b001: step = 3'd0;
                3'b011: step = 3'd1;
                3'b010: step = 3'd2;
                3'b110: step = 3'd3;
                3'b100: step = 3'd4;
                3'b101: step = 3'd5;
                default: step = STEP_NONE;
            endcase
        end
    end

    // Map the step index to the phase pair it drives.
    always_comb begin
        legal  = 1'b1;
        hi_fwd = '0;
        lo_fwd = '0;
        case (step)
            3'd0: begin hi_fwd = PH_A; lo_fwd = PH_B; end
            3'd1: begin hi_fwd = PH_A; lo_fwd = PH_C; end
            3'd2: begin hi_fwd = PH_B; lo_fwd = PH_C; end
            3'd3: begin hi_fwd = PH_B; lo_fwd = PH_A; end
            3'd4: begin hi_fwd = PH_C; lo_fwd = PH_A; end
            3'd5: begin hi_fwd = PH_C; lo_fwd = PH_B; end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bldc_tach.sv
// Module: retriggerable fixed-width active-low tach pulse generator.
// Assumes trig is a single-cycle strobe; a new strobe restarts the width.
module bldc_tach #(
    parameter int TACH_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic tach_n
);
    localparam int TW = $clog2(TACH_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(TACH_CYC - 1);

    logic [TW-1:0] remain;

    // Hold tach_n low for TACH_CYC cycles from each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            tach_n <= 1'b1;
        end else if (trig) begin
            remain <= LOAD;
            tach_n <= 1'b0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else begin
            tach_n <= 1'b1;
        end
    end

    // R10
    tach_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !tach_n);
endmodule

// File: rtl/bldc_commutator.sv
// Module: Hall-sensor commutation controller top.
// Synchronizes all inputs, filters the Hall code and decodes it. It then
// applies shutdown, brake, direction and chop rules into registered gate
// enables, and generates the tach pulse and the illegal-code fault flag.
// Assumes all inputs are asynchronous levels. Dead time is added downstream.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int FILT_CYC = 4,
    parameter int TACH_CYC = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic       sel_60,
    input  logic       enable,
    input  logic       dir_fwd,
    input  logic       pwm,
    input  logic       chop_both,
    input  logic       brake,
    input  logic       inhibit,
    output logic [2:0] gate_top,
    output logic [2:0] gate_bot,
    output logic       tach_n,
    output logic       fault_n
);
    localparam int NCTL = 7;
    localparam int NSYN = NCTL + 3;

    logic [NSYN-1:0] raw_in, syn;
    logic [2:0]      hall_s, hall_q;
    logic            hall_ok, hall_evt;
    logic            sel60_s, en_s, fwd_s, pwm_s, both_s, brk_s, inh_s;
    logic            code_ok;
    phase_vec_t      hi_fwd, lo_fwd;
    phase_vec_t      top_nx, bot_nx;
    logic            fault_nx;

    assign raw_in = {inhibit, brake, chop_both, pwm, dir_fwd, enable, sel_60, hall};
    assign {inh_s, brk_s, both_s, pwm_s, fwd_s, en_s, sel60_s, hall_s} = syn;

    bldc_sync #(.WIDTH(NSYN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(raw_in),
        .q_sync (syn)
    );

    bldc_hall_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hall_s  (hall_s),
        .hall_q  (hall_q),
        .hall_ok (hall_ok),
        .hall_evt(hall_evt)
    );

    bldc_decode u_dec (
        .code  (hall_q),
        .sel_60(sel60_s),
        .legal (code_ok),
        .hi_fwd(hi_fwd),
        .lo_fwd(lo_fwd)
    );

    bldc_tach #(.TACH_CYC(TACH_CYC)) u_tach (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (hall_evt),
        .tach_n(tach_n)
    );

    // Priority: inhibit/illegal/disable, then brake, then direction and chop.
    always_comb begin
        fault_nx = !(hall_ok && !code_ok);
        top_nx   = '0;
        bot_nx   = '0;
        if (!hall_ok || inh_s || !code_ok || !en_s) begin
            top_nx = '0;
            bot_nx = '0;
        end else if (brk_s) begin
            bot_nx = 3'b111;
        end else begin
            top_nx = fwd_s ? hi_fwd : lo_fwd;
            bot_nx = fwd_s ? lo_fwd : hi_fwd;
            if (!pwm_s) begin
                bot_nx = '0;
                if (both_s) top_nx = '0;
            end
        end
    end

    // Output register for gates and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_top <= '0;
            gate_bot <= '0;
            fault_n  <= 1'b1;
        end else begin
            gate_top <= top_nx;
            gate_bot <= bot_nx;
            fault_n  <= fault_nx;
        end
    end

    // R13
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_top & gate_bot) == 3'b000);

    // R13
    one_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_top));

    // R11
    inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_s |=> (gate_top == 3'b000 && gate_bot == 3'b000));

    // R8
    brake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_s && en_s && !inh_s && hall_ok && code_ok) |=>
            (gate_bot == 3'b111 && gate_top == 3'b000));

    // R6
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_top == 3'b000 && gate_bot == 3'b000));

    // R7
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (gate_top == 3'b000 && gate_bot == 3'b000));
endmodule

// File: tb/bldc_commutator_bench.sv
// Bench: directed corner cases plus seeded random stimulus against a model.
module bldc_commutator_bench;
    localparam int FILT = 4;
    localparam int TACH = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b001;
    logic       sel_60 = 1'b0, enable = 1'b1, dir_fwd = 1'b1, pwm = 1'b1;
    logic       chop_both = 1'b0, brake = 1'b0, inhibit = 1'b0;
    logic [2:0] gate_top, gate_bot;
    logic       tach_n, fault_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bldc_commutator #(.FILT_CYC(FILT), .TACH_CYC(TACH)) u_bldc_commutator (
        .clk(clk), .rst_n(rst_n), .hall(hall), .sel_60(sel_60),
        .enable(enable), .dir_fwd(dir_fwd), .pwm(pwm), .chop_both(chop_both),
        .brake(brake), .inhibit(inhibit), .gate_top(gate_top),
        .gate_bot(gate_bot), .tach_n(tach_n), .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Step index from code, 7 when illegal.
    function automatic int step_of(input logic [2:0] c, input logic s60);
        if (s60) begin
            case (c)
                3'b001: return 0; 3'b011: return 1; 3'b111: return 2;
                3'b110: return 3; 3'b100: return 4; 3'b000: return 5;
                default: return 7;
            endcase
        end
        case (c)
            3'b001: return 0; 3'b011: return 1; 3'b010: return 2;
            3'b110: return 3; 3'b100: return 4; 3'b101: return 5;
            default: return 7;
        endcase
    endfunction

    // Expected {fault_n, gate_top, gate_bot}.
    function automatic logic [6:0] model(input logic [2:0] c, input logic s60,
        input logic en, input logic fwd, input logic pw, input logic both,
        input logic brk, input logic inh);
        int st, tp, bp;
        logic [2:0] t, b, x;
        st = step_of(c, s60);
        if (st == 7) return 7'b0_000_000;
        if (inh || !en) return 7'b1_000_000;
        if (brk) return 7'b1_000_111;
        tp = st / 2;
        bp = (tp + 1 + (st % 2)) % 3;
        t = 3'(1 << tp);
        b = 3'(1 << bp);
        if (!fwd) begin x = t; t = b; b = x; end
        if (!pw) begin b = 3'b000; if (both) t = 3'b000; end
        return {1'b1, t, b};
    endfunction

    function automatic logic [6:0] exp_now();
        return model(hall, sel_60, enable, dir_fwd, pwm, chop_both, brake, inhibit);
    endfunction

    function automatic logic [6:0] got();
        return {fault_n, gate_top, gate_bot};
    endfunction

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [6:0] held;
        logic       tach_seen;
        int         w;
        // R14 reset state
        settle(4);
        chk("R14 gates", {2'b0, gate_top, gate_bot}, 8'h00);
        chk("R14 tach_n/fault_n", {6'b0, tach_n, fault_n}, 8'h03);
        rst_n = 1'b1;
        settle(20);
        // R3 basic 120-degree map
        chk("R3 code001", {1'b0, got()}, {1'b0, exp_now()});
        chk("R3 code001 direct", {2'b0, gate_top, gate_bot}, 8'b00_001_010);

        // R1 Hall latency and R10 tach timing
        hall = 3'b011;
        settle(7);
        chk("R1 not at edge 7", {2'b0, gate_top, gate_bot}, 8'b00_001_010);
        chk("R10 tach idle at edge 7", {7'b0, tach_n}, 8'h01);
        settle(1);
        chk("R1 at edge 8", {2'b0, gate_top, gate_bot}, 8'b00_001_100);
        chk("R10 tach low at edge 8", {7'b0, tach_n}, 8'h00);
        w = 0;
        while (tach_n == 1'b0 && w < 1000) begin
            w++;
            @(negedge clk);
        end
        chk("R10 tach width", 8'(w), 8'(TACH));

        // R2 short glitch ignored
        held = got();
        tach_seen = 1'b0;
        hall = 3'b010;
        @(posedge clk); @(posedge clk); @(negedge clk);
        hall = 3'b011;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (tach_n == 1'b0) tach_seen = 1'b1;
        end
        chk("R2 gates held", {1'b0, got()}, {1'b0, held});
        chk("R2 no tach", {7'b0, tach_seen}, 8'h00);

        // R12 control latency and R7 disable
        enable = 1'b0;
        settle(2);
        chk("R12 not at edge 2", {2'b0, gate_top, gate_bot}, 8'b00_001_100);
        settle(1);
        chk("R7 R12 off at edge 3", {2'b0, gate_top, gate_bot}, 8'h00);
        enable = 1'b1;
        settle(6);

        // R9 chop modes
        pwm = 1'b0; chop_both = 1'b0;
        settle(6);
        chk("R9 bottom-only chop", {2'b0, gate_top, gate_bot}, 8'b00_001_000);
        chop_both = 1'b1;
        settle(6);
        chk("R9 both chop", {2'b0, gate_top, gate_bot}, 8'h00);
        pwm = 1'b1; chop_both = 1'b0;

        // R8 brake
        brake = 1'b1;
        settle(6);
        chk("R8 brake", {2'b0, gate_top, gate_bot}, 8'b00_000_111);
        brake = 1'b0;

        // R11 inhibit, code changes underneath
        inhibit = 1'b1;
        hall = 3'b110;
        settle(12);
        chk("R11 inhibited", {2'b0, gate_top, gate_bot}, 8'h00);
        inhibit = 1'b0;
        settle(6);
        chk("R11 resume code110", {2'b0, gate_top, gate_bot}, 8'b00_010_001);

        // R5 reverse
        dir_fwd = 1'b0;
        settle(6);
        chk("R5 reverse code110", {2'b0, gate_top, gate_bot}, 8'b00_001_010);
        dir_fwd = 1'b1;

        // R6 illegal codes in both spacings
        hall = 3'b111;
        settle(12);
        chk("R6 120 code111", {1'b0, got()}, 8'h00);
        hall = 3'b000;
        settle(12);
        chk("R6 120 code000", {1'b0, got()}, 8'h00);
        sel_60 = 1'b1;
        settle(6);
        chk("R4 60 code000", {1'b0, got()}, 8'b0_1_100_010);
        hall = 3'b010;
        settle(12);
        chk("R6 60 code010", {1'b0, got()}, 8'h00);
        hall = 3'b111;
        settle(12);
        chk("R4 60 code111", {1'b0, got()}, 8'b0_1_010_100);

        // R3 R4 R5 R8 R9 R13 random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 300; k++) begin
            logic [9:0] r;
            r = 10'($urandom());
            hall = r[2:0];
            sel_60 = r[3];
            dir_fwd = r[4];
            pwm = r[5];
            chop_both = r[6];
            enable = (r[9:7] != 3'b000);
            brake = ($urandom_range(0, 7) == 0);
            inhibit = ($urandom_range(0, 9) == 0);
            settle(12);
            chk(sel_60 ? "R4 random" : "R3 random", {1'b0, got()}, {1'b0, exp_now()});
            chk("R13 no shoot",
                {5'b0, gate_top & gate_bot}, 8'h00);
        end

        done = 1;
        summary();
    end
endmodule